// File: doc/BRIEF.md
# Windowed Pixel Sample Buffer with Daisy-Chained Drain

This block is the digital back end of a small trigger-less timing pixel matrix of 16 channels (4x4). Every clock cycle each channel presents an 8-bit charge sample, a 10-bit arrival-time code and a threshold-crossing flag. A threshold crossing on a channel opens an acquisition window of programmable length. While the window is open, that channel records each cycle's sample into its own eight-entry ring. When a ring is full, the oldest entry is overwritten.

A readout request takes a snapshot of which channels hold data. The block then drains those channels one word at a time through a single valid/ready output, in ascending channel order. Each word is tagged with its channel index. The final word of the drain carries a last flag. While a channel is being drained it accepts no new samples, and its ring is emptied once its final entry has left.

Top module: `pixbuf_chain_top`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low and every ring is empty.
- R2: A rising threshold flag on a channel with no open window opens a window of L cycles, starting with that cycle. L is `win_len`, with 0 treated as 1 and values above 8 treated as 8. Each cycle of the window stores one word: flag in bit 18, time code in bits 17:8, charge in bits 7:0.
- R3: A threshold flag seen while a window is already open neither extends nor restarts that window.
- R4: Each ring holds at most 8 words and overwrites its oldest word when full. A drain emits only the stored words, oldest first.
- R5: A drain visits the channels that held data at the request, in order 0 to 15. `out_pix` carries the channel index. Empty channels cost no output cycle, so words are emitted on consecutive cycles while `out_ready` stays high.
- R6: While `out_valid` is high and `out_ready` is low, `out_word`, `out_pix` and `out_valid` hold steady. A word counts as transferred only when `out_valid` and `out_ready` are both high.
- R7: `out_last` is high only together with the final word of a drain.
- R8: A request that arrives while a drain is in progress is ignored. A request when every ring is empty produces no output.
- R9: A channel that is being drained neither stores samples nor opens a window. After its final word is transferred its ring is empty, and capture resumes on the next hit.
- R10: A channel that sees no threshold flag stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_len | input | 4 | Window length in cycles (clamped to 1..8) |
| disc_in | input | 16 | Threshold flag, one bit per channel |
| adc_in | input | 128 | Charge samples, channel i in bits 8i+7:8i |
| tdc_in | input | 160 | Arrival-time codes, channel i in bits 10i+9:10i |
| rd_req | input | 1 | Readout request |
| out_ready | input | 1 | Downstream can take a word |
| out_valid | output | 1 | Output word present |
| out_word | output | 19 | Stored word {flag, time code, charge} |
| out_pix | output | 4 | Channel index of the output word |
| out_last | output | 1 | Final word of the drain |

## Verification
The bench uses the default build: 16 channels, ring depth 8, 8-bit charge and 10-bit time code. This is small enough that ring wraparound, saturation and clamping of the window length to the ring depth can all be reached within a few tens of cycles. A bench-side model of the windows and rings predicts every word, channel tag and last flag. The tests cover windows that overflow a ring, hits that land on a channel while it is being drained, and a drain that meets an irregular `out_ready` pattern.

// File: rtl/pixbuf_pkg.sv
package pixbuf_pkg;

  localparam int unsigned DEF_NPIX  = 16;
  localparam int unsigned DEF_DEPTH = 8;
  localparam int unsigned DEF_ADC_W = 8;
  localparam int unsigned DEF_TDC_W = 10;

  // Effective window length: zero counts as one, ring depth is the ceiling.
  function automatic int unsigned win_clamp(input int unsigned len, input int unsigned depth);
    if (len == 0) return 1;
    if (len > depth) return depth;
    return len;
  endfunction

  // Ring slot of the idx-th oldest entry given write pointer and fill count.
  function automatic int unsigned ring_slot(input int unsigned wr_ptr, input int unsigned fill,
                                            input int unsigned idx, input int unsigned depth);
    return (wr_ptr + depth - (fill % depth) + idx) % depth;
  endfunction

endpackage

// File: rtl/pixbuf_window.sv
module pixbuf_window #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LEN_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] win_len,
  input  logic             disc,
  input  logic             freeze,
  output logic             wr_en
);
  localparam int unsigned REM_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [REM_W-1:0] win_rem;
  logic [REM_W-1:0] len_m1;
  logic             win_start;
  logic             win_open;

  assign len_m1    = REM_W'(pixbuf_pkg::win_clamp(32'(win_len), DEPTH) - 1);
  assign win_start = disc && !freeze && (win_rem == '0);
  assign win_open  = win_start || (win_rem != '0);
  assign wr_en     = win_open && !freeze;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_rem <= '0;
    end else if (win_start) begin
      win_rem <= len_m1;
    end else if (win_rem != '0) begin
      win_rem <= win_rem - REM_W'(1);
    end
  end

  // R3: an open window keeps counting down through further hits
  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rem != '0) && disc |=> win_rem == REM_W'($past(win_rem) - REM_W'(1)));

  // R9: a frozen channel never opens a window
  assert_freeze_blocks_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze && (win_rem == '0) |=> win_rem == '0);

endmodule

// File: rtl/pixbuf_ring.sv
module pixbuf_ring #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned WORD_W = 19,
  parameter int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              clr,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic [CNT_W-1:0]  fill
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_slot;
  logic              full;

  assign full    = (fill == CNT_W'(DEPTH));
  assign rd_slot = PTR_W'(pixbuf_pkg::ring_slot(32'(wr_ptr), 32'(fill), 32'(rd_idx), DEPTH));
  assign rd_word = mem[rd_slot];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      fill   <= '0;
    end else if (clr) begin
      fill <= '0;
    end else if (wr_en) begin
      wr_ptr <= (32'(wr_ptr) == DEPTH - 1) ? '0 : wr_ptr + PTR_W'(1);
      if (!full) fill <= fill + CNT_W'(1);
    end
  end

  // R4: fill saturates at the ring depth
  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  // R4: a write into a non-full ring adds exactly one entry
  assert_fill_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !clr && !full |=> fill == CNT_W'($past(fill) + CNT_W'(1)));

endmodule

// File: rtl/pixbuf_pixel.sv
module pixbuf_pixel #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned ADC_W = 8,
  parameter int unsigned TDC_W = 10,
  parameter int unsigned LEN_W = $clog2(DEPTH) + 1,
  parameter int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1),
  parameter int unsigned WORD_W = 1 + TDC_W + ADC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  win_len,
  input  logic              disc,
  input  logic [ADC_W-1:0]  adc,
  input  logic [TDC_W-1:0]  tdc,
  input  logic              freeze,
  input  logic              clr,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic [CNT_W-1:0]  fill
);
  logic wr_en;

  pixbuf_window #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .win_len(win_len), .disc(disc),
    .freeze(freeze), .wr_en(wr_en)
  );

  pixbuf_ring #(.DEPTH(DEPTH), .WORD_W(WORD_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word({disc, tdc, adc}),
    .clr(clr), .rd_idx(rd_idx), .rd_word(rd_word), .fill(fill)
  );

  // R9: a frozen channel's ring does not change unless it is being cleared
  assert_frozen_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze && !clr |=> $stable(fill));

  // R10: no hit and no open window means nothing is stored
  assert_idle_no_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !disc && !wr_en && !clr |=> $stable(fill));

endmodule

// File: rtl/pixbuf_seq.sv
module pixbuf_seq #(
  parameter int unsigned NPIX   = 16,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned WORD_W = 19,
  parameter int unsigned PIX_W  = (NPIX > 1) ? $clog2(NPIX) : 1,
  parameter int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_req,
  input  logic                   out_ready,
  input  logic [NPIX*CNT_W-1:0]  fill_flat,
  input  logic [NPIX*WORD_W-1:0] word_flat,
  output logic [NPIX-1:0]        freeze,
  output logic [NPIX-1:0]        clr,
  output logic [PTR_W-1:0]       rd_idx,
  output logic                   out_valid,
  output logic [WORD_W-1:0]      out_word,
  output logic [PIX_W-1:0]       out_pix,
  output logic                   out_last
);
  logic              busy;
  logic [NPIX-1:0]   pend;
  logic [PIX_W-1:0]  cur;
  logic [NPIX-1:0]   nonempty;
  logic [NPIX-1:0]   cur_hot;
  logic [NPIX-1:0]   rest;
  logic [CNT_W-1:0]  cur_fill;
  logic              final_entry;
  logic              fire;

  function automatic logic [PIX_W-1:0] lowest(input logic [NPIX-1:0] m);
    logic [PIX_W-1:0] r;
    r = '0;
    for (int i = NPIX - 1; i >= 0; i--) if (m[i]) r = PIX_W'(i);
    return r;
  endfunction

  for (genvar g = 0; g < NPIX; g++) begin : g_flags
    assign nonempty[g] = fill_flat[g*CNT_W +: CNT_W] != '0;
    assign cur_hot[g]  = busy && (cur == PIX_W'(g));
  end

  assign cur_fill    = fill_flat[cur*CNT_W +: CNT_W];
  assign final_entry = CNT_W'(rd_idx) == cur_fill - CNT_W'(1);
  assign rest        = pend & ~cur_hot;
  assign fire        = busy && out_ready;

  assign freeze    = cur_hot;
  assign clr       = (fire && final_entry) ? cur_hot : '0;
  assign out_valid = busy;
  assign out_word  = word_flat[cur*WORD_W +: WORD_W];
  assign out_pix   = cur;
  assign out_last  = busy && final_entry && (rest == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pend   <= '0;
      cur    <= '0;
      rd_idx <= '0;
    end else if (!busy) begin
      if (rd_req && (nonempty != '0)) begin
        busy   <= 1'b1;
        pend   <= nonempty;
        cur    <= lowest(nonempty);
        rd_idx <= '0;
      end
    end else if (out_ready) begin
      if (final_entry) begin
        pend   <= rest;
        rd_idx <= '0;
        if (rest != '0) cur <= lowest(rest);
        else            busy <= 1'b0;
      end else begin
        rd_idx <= rd_idx + PTR_W'(1);
      end
    end
  end

  // R7: last flag only accompanies a presented word
  assert_last_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R6: a stalled word is held unchanged
  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_pix));

  // R8: a request during a drain leaves the snapshot untouched
  assert_req_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_req && !out_ready |=> $stable(pend) && $stable(cur));

  // R9: at most one channel is frozen at a time
  assert_single_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(freeze));

  // R5: the drain never presents a channel that holds no data
  assert_cur_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cur_fill != '0);

endmodule

// File: rtl/pixbuf_chain_top.sv
module pixbuf_chain_top #(
  parameter int unsigned NPIX  = pixbuf_pkg::DEF_NPIX,
  parameter int unsigned DEPTH = pixbuf_pkg::DEF_DEPTH,
  parameter int unsigned ADC_W = pixbuf_pkg::DEF_ADC_W,
  parameter int unsigned TDC_W = pixbuf_pkg::DEF_TDC_W,
  parameter int unsigned LEN_W = $clog2(DEPTH) + 1,
  parameter int unsigned WORD_W = 1 + TDC_W + ADC_W,
  parameter int unsigned PIX_W = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LEN_W-1:0]      win_len,
  input  logic [NPIX-1:0]       disc_in,
  input  logic [NPIX*ADC_W-1:0] adc_in,
  input  logic [NPIX*TDC_W-1:0] tdc_in,
  input  logic                  rd_req,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [WORD_W-1:0]     out_word,
  output logic [PIX_W-1:0]      out_pix,
  output logic                  out_last
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [NPIX*CNT_W-1:0]  fill_flat;
  logic [NPIX*WORD_W-1:0] word_flat;
  logic [NPIX-1:0]        freeze;
  logic [NPIX-1:0]        clr;
  logic [PTR_W-1:0]       rd_idx;

  for (genvar g = 0; g < NPIX; g++) begin : g_pix
    pixbuf_pixel #(
      .DEPTH(DEPTH), .ADC_W(ADC_W), .TDC_W(TDC_W), .LEN_W(LEN_W),
      .PTR_W(PTR_W), .CNT_W(CNT_W), .WORD_W(WORD_W)
    ) u_pix (
      .clk(clk), .rst_n(rst_n), .win_len(win_len), .disc(disc_in[g]),
      .adc(adc_in[g*ADC_W +: ADC_W]), .tdc(tdc_in[g*TDC_W +: TDC_W]),
      .freeze(freeze[g]), .clr(clr[g]), .rd_idx(rd_idx),
      .rd_word(word_flat[g*WORD_W +: WORD_W]), .fill(fill_flat[g*CNT_W +: CNT_W])
    );
  end

  pixbuf_seq #(
    .NPIX(NPIX), .DEPTH(DEPTH), .WORD_W(WORD_W), .PIX_W(PIX_W),
    .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .out_ready(out_ready),
    .fill_flat(fill_flat), .word_flat(word_flat), .freeze(freeze), .clr(clr),
    .rd_idx(rd_idx), .out_valid(out_valid), .out_word(out_word),
    .out_pix(out_pix), .out_last(out_last)
  );

  // R1: nothing is presented in the first cycle after reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !out_last);

endmodule

// File: tb/sim_pixbuf_chain_top.sv
module sim_pixbuf_chain_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   win_len;
  logic [15:0]  disc_in;
  logic [127:0] adc_in;
  logic [159:0] tdc_in;
  logic         rd_req;
  logic         out_ready;
  logic         out_valid;
  logic [18:0]  out_word;
  logic [3:0]   out_pix;
  logic         out_last;

  pixbuf_chain_top u0 (
    .clk(clk), .rst_n(rst_n), .win_len(win_len), .disc_in(disc_in),
    .adc_in(adc_in), .tdc_in(tdc_in), .rd_req(rd_req), .out_ready(out_ready),
    .out_valid(out_valid), .out_word(out_word), .out_pix(out_pix), .out_last(out_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  int stamp = 0;
  int words = 0;

  // bench-side model
  logic [18:0] mq [NP][$];
  int          wrem [NP];
  bit          ract = 0;
  logic [15:0] rpend = '0;
  int          rcur = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff_len(input int l);
    if (l == 0) return 1;
    if (l > 8) return 8;
    return l;
  endfunction

  function automatic int low_bit(input logic [15:0] m);
    for (int i = 0; i < NP; i++) if (m[i]) return i;
    return 0;
  endfunction

  // one cycle: drive at negedge, check, update model, advance to next negedge
  task automatic tick(input logic [15:0] d, input bit rq, input bit rdy);
    logic [15:0] pre;
    logic [18:0] w;
    int          frz;
    bit          accept;
    bit          explast;
    disc_in = d; rd_req = rq; out_ready = rdy; stamp++;
    for (int i = 0; i < NP; i++) begin
      adc_in[i*8 +: 8]   = 8'((stamp * 7 + i * 11) & 255);
      tdc_in[i*10 +: 10] = 10'((stamp * 13 + i * 37) & 1023);
    end
    #1;
    frz = ract ? rcur : -1;
    for (int i = 0; i < NP; i++) pre[i] = (mq[i].size() != 0);
    accept = rq && !ract && (pre != '0);
    chk(out_valid == ract, "R5 valid", out_valid, ract);
    if (ract) begin
      explast = (mq[rcur].size() == 1) && ((rpend & ~(16'(1) << rcur)) == '0);
      chk(out_word == mq[rcur][0], "R4 word", out_word, mq[rcur][0]);
      chk(out_pix == 4'(rcur), "R5 pix", out_pix, rcur);
      chk(out_last == explast, "R7 last", out_last, explast);
      if (rdy) begin
        void'(mq[rcur].pop_front());
        words++;
        if (mq[rcur].size() == 0) begin
          rpend[rcur] = 1'b0;
          if (rpend == '0) ract = 0;
          else rcur = low_bit(rpend);
        end
      end
    end else begin
      chk(out_last == 1'b0, "R7 idle last", out_last, 0);
    end
    for (int i = 0; i < NP; i++) begin
      w = {d[i], tdc_in[i*10 +: 10], adc_in[i*8 +: 8]};
      if (wrem[i] > 0) begin
        if (i != frz) begin
          if (mq[i].size() == 8) void'(mq[i].pop_front());
          mq[i].push_back(w);
        end
        wrem[i]--;
      end else if (d[i] && i != frz) begin
        if (mq[i].size() == 8) void'(mq[i].pop_front());
        mq[i].push_back(w);
        wrem[i] = eff_len(int'(win_len)) - 1;
      end
    end
    if (accept) begin
      ract = 1; rpend = pre; rcur = low_bit(pre);
    end
    @(posedge clk); @(negedge clk);
  endtask

  // drain everything; optional hit vector injected at one cycle, req held if asked
  task automatic readout(input int mode, input logic [15:0] inj, input int inj_at,
                         input bit hold_req, output int n, output int cyc);
    int k = 0;
    words = 0;
    do begin
      tick((k == inj_at) ? inj : 16'h0, (k == 0) || hold_req,
           (mode == 0) ? 1'b1 : (k % 3 != 1));
      k++;
    end while (ract && k < 400);
    cyc = k;
    for (int j = 0; j < 3; j++) tick(16'h0, hold_req, 1'b1);
    n = words;
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) tick(16'h0, 1'b0, 1'b1);
  endtask

  task automatic t_reset;
    int n, c;
    chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
    chk(out_last == 1'b0, "R1 last", out_last, 0);
    readout(0, 16'h0, -1, 0, n, c);
    chk(n == 0, "R1 R8 empty read", n, 0);
  endtask

  task automatic t_window(input int len, input int pix, input int expn);
    int n, c;
    win_len = 4'(len);
    tick(16'(1) << pix, 1'b0, 1'b1);
    idle(10);
    readout(0, 16'h0, -1, 0, n, c);
    chk(n == expn, "R2 window words", n, expn);
  endtask

  task automatic t_no_restart;
    int n, c;
    win_len = 4'd4;
    tick(16'h0080, 1'b0, 1'b1);
    idle(1);
    tick(16'h0080, 1'b0, 1'b1);
    idle(6);
    readout(0, 16'h0, -1, 0, n, c);
    chk(n == 4, "R3 no restart", n, 4);
  endtask

  task automatic t_overflow;
    int n, c;
    win_len = 4'd8;
    tick(16'h0008, 1'b0, 1'b1);
    idle(7);
    tick(16'h0008, 1'b0, 1'b1);
    idle(9);
    readout(0, 16'h0, -1, 0, n, c);
    chk(n == 8, "R4 overflow keeps 8", n, 8);
  endtask

  task automatic t_chain;
    int n, c;
    win_len = 4'd2;
    tick(16'h8201, 1'b0, 1'b1);
    idle(4);
    readout(0, 16'h0, -1, 0, n, c);
    chk(n == 6, "R5 chain words", n, 6);
    chk(c == 7, "R5 no gap cycles", c, 7);
  endtask

  task automatic t_stall;
    int n, c;
    win_len = 4'd3;
    tick(16'h0006, 1'b0, 1'b1);
    idle(4);
    readout(1, 16'h0, -1, 0, n, c);
    chk(n == 6, "R6 stalled drain words", n, 6);
  endtask

  task automatic t_busy_req;
    int n, c;
    win_len = 4'd5;
    tick(16'h0010, 1'b0, 1'b1);
    idle(6);
    readout(0, 16'h0, -1, 1, n, c);
    chk(n == 5, "R8 busy request ignored", n, 5);
  endtask

  task automatic t_freeze;
    int n, c;
    win_len = 4'd8;
    tick(16'h0021, 1'b0, 1'b1);
    idle(9);
    readout(0, 16'h0021, 3, 0, n, c);
    chk(n >= 9, "R9 drain count", n, 9);
    readout(0, 16'h0, -1, 0, n, c);
    chk(n == 0, "R9 cleared and frozen hit dropped", n, 0);
    win_len = 4'd2;
    tick(16'h0001, 1'b0, 1'b1);
    idle(3);
    readout(0, 16'h0, -1, 0, n, c);
    chk(n == 2, "R9 capture resumes", n, 2);
  endtask

  task automatic t_no_hit;
    int n, c;
    idle(20);
    readout(0, 16'h0, -1, 0, n, c);
    chk(n == 0, "R10 no hit no data", n, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) wrem[i] = 0;
    rst_n = 1'b0; win_len = 4'd1; disc_in = '0; adc_in = '0; tdc_in = '0;
    rd_req = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_window(3, 2, 3);
    t_window(0, 11, 1);
    t_window(12, 6, 8);
    t_no_restart;
    t_overflow;
    t_chain;
    t_stall;
    t_busy_req;
    t_freeze;
    t_no_hit;
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule